// File: doc/BRIEF.md
# Privileged shadow register file

This block is a 32-entry integer register file in which a fixed group of register indices has a second, private copy for privileged code. While the block is in privileged mode, reads and writes to a banked index reach the shadow copy. In user mode they reach the normal copy. Every other index has a single copy that both modes share. Code that enters privileged mode therefore gets scratch registers without saving the user's values first.

The mode changes through two strobes, one to enter and one to leave. Each strobe takes effect on the clock edge after it is sampled. The mode is held as one bank-select bit per index; no data is ever copied between banks. A request to leave is held back, with no error, when bit 0 of the saved return address is set. A request that would not change the mode sets a sticky error flag and leaves the mode as it was. The file has two combinational read ports and one write port.

Top module: `privbank_regfile`

## Requirements
- R1: While reset is asserted, the block is in privileged mode, the error flag is 0 and every register reads 0. On the first clock edge after reset is released, registers 0 and 16 are loaded with `cpu_id`.
- R2: The banked indices are 8 to 14 and 25 (bit mask 0x0200_7F00). In privileged mode these indices read and write the shadow copy, and in user mode they use the normal copy. All other indices use the normal copy in both modes.
- R3: `enter_req` sampled in user mode makes `priv_mode` 1 after that edge. `exit_req` sampled in privileged mode with `ret_addr_lsb` = 0 makes `priv_mode` 0 after that edge. Without a strobe, the mode does not change.
- R4: `exit_req` in privileged mode with `ret_addr_lsb` = 1 leaves the block in privileged mode and does not set the error flag.
- R5: Any of the following sets `swap_err` and leaves the mode unchanged: `enter_req` in privileged mode, `exit_req` in user mode, or both strobes in the same cycle.
- R6: Once set, `swap_err` stays 1 until reset.
- R7: Index 31 always reads 0 on both ports. Writes to index 31 are ignored.
- R8: A write sampled on the same edge as a mode change goes to the bank that was selected before the change.
- R9: A write appears on both read ports from the cycle after its edge.
- R10: On the first clock edge after reset, writes and mode strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_id | input | 32 | Identifier loaded into registers 0 and 16 after reset |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_data | input | 32 | Write data |
| enter_req | input | 1 | Request to enter privileged mode |
| exit_req | input | 1 | Request to leave privileged mode |
| ret_addr_lsb | input | 1 | Bit 0 of the saved return address; 1 holds the block in privileged mode on exit |
| priv_mode | output | 1 | Current mode, 1 = privileged |
| swap_err | output | 1 | Sticky flag for a redundant or conflicting mode request |

## Verification
The mode properties assume that the strobes and `ret_addr_lsb` are settled before each rising edge. They also assume that a strobe lasts exactly one sampled cycle, so each edge is judged against the mode from the previous cycle. The stimulus meets both assumptions. It drives every input on the falling edge and holds each strobe for one cycle only. It reads the ports just after the following falling edge, once the write and mode registers have settled.

// File: rtl/privbank_pkg.sv
package privbank_pkg;

    // number of set bits in a mask
    function automatic int popcnt(input logic [63:0] v);
        int c = 0;
        for (int j = 0; j < 64; j++) begin
            c += int'(v[j]);
        end
        return c;
    endfunction

    // position of a banked index inside the compact shadow array
    function automatic int slot_of(input logic [63:0] m, input int idx);
        int c = 0;
        for (int j = 0; j < 64; j++) begin
            if ((j < idx) && m[j]) begin
                c++;
            end
        end
        return c;
    endfunction

    typedef enum logic [1:0] {
        REQ_NONE  = 2'b00,
        REQ_EXIT  = 2'b01,
        REQ_ENTER = 2'b10,
        REQ_BOTH  = 2'b11
    } mode_req_e;

endpackage

// File: rtl/privbank_mode_ctl.sv
module privbank_mode_ctl #(
    parameter int                NREG = 32,
    parameter logic [NREG-1:0]   MASK = 32'h0200_7F00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enter_req,
    input  logic            exit_req,
    input  logic            ret_addr_lsb,
    output logic            init_o,
    output logic            priv_o,
    output logic            err_o,
    output logic [NREG-1:0] sel_o
);
    import privbank_pkg::*;

    typedef struct packed {
        logic            init;
        logic            priv;
        logic            err;
        logic [NREG-1:0] sel;
    } mode_st_t;

    mode_st_t  st_d, st_q;
    mode_req_e req;

    assign req = mode_req_e'({enter_req, exit_req});

    always_comb begin
        st_d = st_q;
        if (st_q.init) begin
            st_d.init = 1'b0;
        end else begin
            case (req)
                REQ_ENTER: begin
                    if (st_q.priv) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.priv = 1'b1;
                        st_d.sel  = MASK;
                    end
                end
                REQ_EXIT: begin
                    if (!st_q.priv) begin
                        st_d.err = 1'b1;
                    end else if (!ret_addr_lsb) begin
                        st_d.priv = 1'b0;
                        st_d.sel  = '0;
                    end
                end
                REQ_BOTH: st_d.err = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.init <= 1'b1;
            st_q.priv <= 1'b1;
            st_q.err  <= 1'b0;
            st_q.sel  <= MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_o = st_q.init;
    assign priv_o = st_q.priv;
    assign err_o  = st_q.err;
    assign sel_o  = st_q.sel;

endmodule

// File: rtl/privbank_storage.sv
module privbank_storage #(
    parameter int              NREG   = 32,
    parameter int              W      = 32,
    parameter logic [NREG-1:0] MASK   = 32'h0200_7F00,
    parameter int              ID_A   = 0,
    parameter int              ID_B   = 16,
    parameter int              NSH    = 8,
    localparam int             AW     = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init,
    input  logic [W-1:0]             cpu_id,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [NREG-1:0]          sel,
    output logic [NREG-1:0][W-1:0]   norm_o,
    output logic [NSH-1:0][W-1:0]    shad_o
);
    import privbank_pkg::*;

    localparam int ZIDX = NREG - 1;
    localparam int SLW  = (NSH > 1) ? $clog2(NSH) : 1;

    typedef struct packed {
        logic [NREG-1:0][W-1:0] norm;
        logic [NSH-1:0][W-1:0]  shad;
    } store_st_t;

    store_st_t      st_d, st_q;
    logic [SLW-1:0] wslot;
    logic           to_shadow;

    always_comb begin
        wslot     = SLW'(slot_of(64'(MASK), int'(wr_idx)));
        to_shadow = MASK[wr_idx] && sel[wr_idx];
        st_d      = st_q;
        if (init) begin
            st_d.norm[ID_A] = cpu_id;
            st_d.norm[ID_B] = cpu_id;
        end else if (wr_en && (wr_idx != AW'(ZIDX))) begin
            if (to_shadow) begin
                st_d.shad[wslot] = wr_data;
            end else begin
                st_d.norm[wr_idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign norm_o = st_q.norm;
    assign shad_o = st_q.shad;

endmodule

// File: rtl/privbank_read_port.sv
module privbank_read_port #(
    parameter int              NREG = 32,
    parameter int              W    = 32,
    parameter logic [NREG-1:0] MASK = 32'h0200_7F00,
    parameter int              NSH  = 8,
    localparam int             AW   = $clog2(NREG)
) (
    input  logic [AW-1:0]          idx,
    input  logic [NREG-1:0][W-1:0] norm,
    input  logic [NSH-1:0][W-1:0]  shad,
    input  logic [NREG-1:0]        sel,
    output logic [W-1:0]           data
);
    import privbank_pkg::*;

    localparam int ZIDX = NREG - 1;
    localparam int SLW  = (NSH > 1) ? $clog2(NSH) : 1;

    logic [SLW-1:0] rslot;

    always_comb begin
        rslot = SLW'(slot_of(64'(MASK), int'(idx)));
        if (idx == AW'(ZIDX)) begin
            data = '0;
        end else if (MASK[idx] && sel[idx]) begin
            data = shad[rslot];
        end else begin
            data = norm[idx];
        end
    end

endmodule

// File: rtl/privbank_regfile.sv
module privbank_regfile #(
    parameter int                NREG      = 32,
    parameter int                DATA_W    = 32,
    parameter logic [NREG-1:0]   BANK_MASK = 32'h0200_7F00,
    parameter int                ID_IDX_A  = 0,
    parameter int                ID_IDX_B  = 16,
    localparam int               AW        = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cpu_id,
    input  logic [AW-1:0]     rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              enter_req,
    input  logic              exit_req,
    input  logic              ret_addr_lsb,
    output logic              priv_mode,
    output logic              swap_err
);
    import privbank_pkg::*;

    localparam int NSH   = popcnt(64'(BANK_MASK));
    localparam int NPORT = 2;

    logic                        init_pulse;
    logic [NREG-1:0]             bank_sel;
    logic [NREG-1:0][DATA_W-1:0] norm_bank;
    logic [NSH-1:0][DATA_W-1:0]  shad_bank;
    logic [NPORT-1:0][AW-1:0]    rd_idx_arr;
    logic [NPORT-1:0][DATA_W-1:0] rd_data_arr;

    privbank_mode_ctl #(
        .NREG (NREG),
        .MASK (BANK_MASK)
    ) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_req    (enter_req),
        .exit_req     (exit_req),
        .ret_addr_lsb (ret_addr_lsb),
        .init_o       (init_pulse),
        .priv_o       (priv_mode),
        .err_o        (swap_err),
        .sel_o        (bank_sel)
    );

    privbank_storage #(
        .NREG (NREG),
        .W    (DATA_W),
        .MASK (BANK_MASK),
        .ID_A (ID_IDX_A),
        .ID_B (ID_IDX_B),
        .NSH  (NSH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (init_pulse),
        .cpu_id  (cpu_id),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sel     (bank_sel),
        .norm_o  (norm_bank),
        .shad_o  (shad_bank)
    );

    assign rd_idx_arr[0] = rd_a_idx;
    assign rd_idx_arr[1] = rd_b_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        privbank_read_port #(
            .NREG (NREG),
            .W    (DATA_W),
            .MASK (BANK_MASK),
            .NSH  (NSH)
        ) u_rd (
            .idx  (rd_idx_arr[p]),
            .norm (norm_bank),
            .shad (shad_bank),
            .sel  (bank_sel),
            .data (rd_data_arr[p])
        );
    end

    assign rd_a_data = rd_data_arr[0];
    assign rd_b_data = rd_data_arr[1];

endmodule

// File: rtl/privbank_chk.sv
module privbank_chk #(
    parameter int AW = 5,
    parameter int W  = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enter_req,
    input logic          exit_req,
    input logic          ret_addr_lsb,
    input logic          init_q,
    input logic          priv_mode,
    input logic          swap_err,
    input logic [AW-1:0] rd_a_idx,
    input logic [W-1:0]  rd_a_data,
    input logic [AW-1:0] rd_b_idx,
    input logic [W-1:0]  rd_b_data
);
    localparam logic [AW-1:0] ZIDX = '1;

    AST_INIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |-> (priv_mode && !swap_err));  // R1

    AST_INIT_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        init_q |=> (priv_mode && !swap_err));  // R10

    AST_ENTER_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_q && enter_req && !exit_req && !priv_mode) |=> priv_mode);  // R3

    AST_EXIT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_q && exit_req && !enter_req && priv_mode && !ret_addr_lsb) |=> !priv_mode);  // R3

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!enter_req && !exit_req) |=> $stable(priv_mode));  // R3

    AST_EXIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_q && exit_req && !enter_req && priv_mode && ret_addr_lsb)
        |=> (priv_mode && (swap_err == $past(swap_err))));  // R4

    AST_REDUNDANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_q && ((enter_req && !exit_req && priv_mode) || (exit_req && !enter_req && !priv_mode)))
        |=> (swap_err && $stable(priv_mode)));  // R5

    AST_DOUBLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_q && enter_req && exit_req) |=> (swap_err && $stable(priv_mode)));  // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        swap_err |=> swap_err);  // R6

    AST_ZERO_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == ZIDX) |-> (rd_a_data == '0));  // R7

    AST_ZERO_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == ZIDX) |-> (rd_b_data == '0));  // R7

endmodule

bind privbank_regfile privbank_chk #(
    .AW (AW),
    .W  (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_req    (enter_req),
    .exit_req     (exit_req),
    .ret_addr_lsb (ret_addr_lsb),
    .init_q       (init_pulse),
    .priv_mode    (priv_mode),
    .swap_err     (swap_err),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .rd_b_idx     (rd_b_idx),
    .rd_b_data    (rd_b_data)
);

// File: tb/privbank_regfile_tb.sv
`timescale 1ns/1ps
module privbank_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_id = 32'h0000_00C3;
    logic [4:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [4:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        enter_req = 1'b0;
    logic        exit_req = 1'b0;
    logic        ret_addr_lsb = 1'b0;
    logic        priv_mode;
    logic        swap_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] mnorm [32];
    logic [31:0] mshad [32];
    bit          mpriv;
    bit          merr;

    always #2 clk = ~clk;

    privbank_regfile u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_id       (cpu_id),
        .rd_a_idx     (rd_a_idx),
        .rd_a_data    (rd_a_data),
        .rd_b_idx     (rd_b_idx),
        .rd_b_data    (rd_b_data),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .enter_req    (enter_req),
        .exit_req     (exit_req),
        .ret_addr_lsb (ret_addr_lsb),
        .priv_mode    (priv_mode),
        .swap_err     (swap_err)
    );

    // R2 banked set: 8..14 and 25
    function automatic bit banked(input int i);
        return ((i >= 8) && (i <= 14)) || (i == 25);
    endfunction

    function automatic logic [31:0] expect_rd(input int i);
        if (i == 31) return 32'h0;
        if (banked(i) && mpriv) return mshad[i];
        return mnorm[i];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin
            mnorm[i] = '0;
            mshad[i] = '0;
        end
        mpriv = 1'b1;
        merr  = 1'b0;
    endtask

    // compare every index on both ports plus mode and error flag
    task automatic check_all(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(31 - i);
            #0.01;
            chk(rd_a_data == expect_rd(i), $sformatf("%s portA idx=%0d", req, i), rd_a_data, expect_rd(i));
            chk(rd_b_data == expect_rd(31 - i), $sformatf("%s portB idx=%0d", req, 31 - i), rd_b_data, expect_rd(31 - i));
        end
        chk(priv_mode == mpriv, {req, " priv_mode"}, 32'(priv_mode), 32'(mpriv));
        chk(swap_err == merr, {req, " swap_err"}, 32'(swap_err), 32'(merr));
    endtask

    // one cycle of stimulus, applied at the falling edge; model follows the requirements
    task automatic step(input bit we, input int idx, input logic [31:0] d,
                        input bit en, input bit ex, input bit ret, input bit init_edge);
        wr_en        = we;
        wr_idx       = 5'(idx);
        wr_data      = d;
        enter_req    = en;
        exit_req     = ex;
        ret_addr_lsb = ret;
        @(posedge clk);
        if (init_edge) begin
            mnorm[0]  = cpu_id;
            mnorm[16] = cpu_id;
        end else begin
            if (we && (idx != 31)) begin
                if (banked(idx) && mpriv) mshad[idx] = d;
                else                      mnorm[idx] = d;
            end
            if (en && ex)   merr = 1'b1;
            else if (en)    begin if (mpriv) merr = 1'b1; else mpriv = 1'b1; end
            else if (ex)    begin if (!mpriv) merr = 1'b1; else if (!ret) mpriv = 1'b0; end
        end
        @(negedge clk);
        wr_en = 1'b0; enter_req = 1'b0; exit_req = 1'b0; ret_addr_lsb = 1'b0;
    endtask

    task automatic do_reset(input logic [31:0] id);
        @(negedge clk);
        rst_n  = 1'b0;
        cpu_id = id;
        model_reset();
        repeat (2) @(negedge clk);
        check_all("R1 reset held");
        rst_n = 1'b1;
        // R10: write and redundant enter on the init edge are ignored
        step(1'b1, 5, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 1'b1);
        check_all("R1 R10 after init edge");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired (all requirements)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset(32'h0000_00C3);

        // R2 R9: fill all indices in privileged mode, read back at once on both ports
        for (int i = 0; i < 32; i++) begin
            logic [31:0] v;
            v = 32'h5A00_0000 + 32'(i) * 32'h0001_0101;
            step(1'b1, i, v, 1'b0, 1'b0, 1'b0, 1'b0);
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(i);
            #0.01;
            chk(rd_a_data == expect_rd(i), $sformatf("R9 portA idx=%0d", i), rd_a_data, expect_rd(i));
            chk(rd_b_data == expect_rd(i), $sformatf("R9 portB idx=%0d", i), rd_b_data, expect_rd(i));
        end
        check_all("R2 R7 priv fill");

        // R4: exit with return bit 0 set stays privileged
        step(1'b0, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0);
        check_all("R4 exit held");

        // R8: write to banked idx 9 on the exit edge lands in the shadow bank
        step(1'b1, 9, 32'h0BAD_0009, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R3 R8 exit with write");

        // R2: fill in user mode
        for (int i = 0; i < 32; i++) begin
            step(1'b1, i, 32'hC000_0000 ^ (32'(i) << 8) ^ 32'(i * 7), 1'b0, 1'b0, 1'b0, 1'b0);
        end
        check_all("R2 R7 user fill");

        // R8: write to banked idx 25 on the enter edge lands in the normal bank
        step(1'b1, 25, 32'h2525_2525, 1'b1, 1'b0, 1'b0, 1'b0);
        check_all("R3 R8 enter with write");

        // R3: no strobe keeps the mode over several cycles
        repeat (3) step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R3 idle");

        // R5: redundant enter
        step(1'b0, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        check_all("R5 redundant enter");

        // R6: legal exit keeps the error flag
        step(1'b0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R3 R6 exit after error");

        // R5: redundant exit, then both strobes together
        step(1'b0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        check_all("R5 redundant exit");
        step(1'b1, 12, 32'h1212_1212, 1'b1, 1'b1, 1'b0, 1'b0);
        check_all("R5 both strobes");

        // R5 in a clean state: both strobes while privileged
        do_reset(32'h7700_0011);
        step(1'b0, 0, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        check_all("R5 R1 both strobes after reset");

        // R7: writes to 31 in user mode
        step(1'b0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        step(1'b1, 31, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R7 user write to 31");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule